// File: doc/BRIEF.md
# Link Integrity Monitor with Media Autoselect

This block decides whether a twisted-pair link is alive and routes the port to the right medium. While the local transmitter is idle it raises a one-cycle request for a link pulse at a fixed period. The twisted-pair driver turns that request into a short positive pulse on the line. On the receive side it takes a strobe for each link pulse detected by the analog front end, and a level that is high while packet data or carrier is present. A received pulse counts as link activity only when its distance from the previous pulse lies inside a valid window. Pulses that come too early or too late are treated as noise.

If no valid pulse and no carrier arrive for a full timeout, the link is declared failed. The block then enables the AUI path and turns off the twisted-pair transmitter, receiver and loopback. Valid activity brings the twisted-pair path back and turns AUI off. A mode input held low keeps twisted-pair operation on whatever the link state. All timers count ticks from a shared prescaler. A test input selects a much shorter tick, so the pulse period and the timeout can be exercised in few cycles. After reset the link is considered failed.

Top module: `link_autoselect`

## Requirements
- R1: After reset `link_fail` is 1, `link_pulse_req` is 0 and, with `auto_sel` high, `aui_en` is 1 and all three twisted-pair enables are 0.
- R2: While `tx_active` stays low, `link_pulse_req` is high for exactly one cycle once every TX_PERIOD ticks.
- R3: While `tx_active` is high, `link_pulse_req` stays 0. The pulse period restarts from zero, so the next request comes TX_PERIOD ticks after `tx_active` falls.
- R4: A `rx_pulse` strobe whose distance from the previous strobe is at least RX_MIN and at most RX_MAX ticks is valid. It clears `link_fail` at the next clock edge and restarts the timeout.
- R5: A strobe closer than RX_MIN ticks to the previous one, or more than RX_MAX ticks after it, does not change `link_fail` and does not restart the timeout. The first strobe after reset counts as too late.
- R6: A cycle with `rx_carrier` high clears `link_fail` at the next edge and restarts the timeout.
- R7: After FAIL_TIMEOUT ticks with no valid strobe and no carrier, `link_fail` rises to 1.
- R8: With `auto_sel` high, `tp_tx_en`, `tp_rx_en` and `tp_lpbk_en` equal the inverse of `link_fail`, and `aui_en` equals `link_fail`.
- R9: With `auto_sel` low, the three twisted-pair enables are 1 and `aui_en` is 0, whatever the link state.
- R10: A tick lasts TICK_NORM clock cycles when `speedup` is 0 and TICK_FAST cycles when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_active | input | 1 | Local transmitter is sending data |
| rx_pulse | input | 1 | One-cycle strobe per received link pulse |
| rx_carrier | input | 1 | Received data or carrier present |
| auto_sel | input | 1 | 1: select medium from link state; 0: twisted-pair always on |
| speedup | input | 1 | Test: use the short tick |
| link_pulse_req | output | 1 | One-cycle request to send a link pulse |
| link_fail | output | 1 | Link failed, active high |
| tp_tx_en | output | 1 | Twisted-pair transmitter enable |
| tp_rx_en | output | 1 | Twisted-pair receiver enable |
| tp_lpbk_en | output | 1 | Twisted-pair loopback enable |
| aui_en | output | 1 | AUI transmit and receive enable |

## Verification
The assertions check on every cycle the properties that hold at each edge. A pulse request lasts one cycle and never comes while transmitting. Carrier always clears the fail flag, and the fail flag rises only on a timeout. A strobe outside the spacing window never lifts a failed link. The enables stay mutually exclusive and follow the mode input. Only the bench's scenarios can show the exact pulse period in both tick modes, the timeout length, and the window edges with strobes placed too early, too late and just inside. The bench compares every output each cycle against its own reference model.

// File: rtl/lia_pkg.sv
package lia_pkg;

  // Spacing window test for received link pulses, in ticks.
  function automatic logic gap_in_window(int unsigned gap, int unsigned lo, int unsigned hi);
    return (gap >= lo) && (gap <= hi);
  endfunction

  // Twisted-pair medium is used when the link is good or autoselect is off.
  function automatic logic tp_selected(logic fail, logic auto_sel);
    return !fail || !auto_sel;
  endfunction

endpackage

// File: rtl/lia_tick_gen.sv
module lia_tick_gen #(
  parameter int TICK_NORM = 10000,
  parameter int TICK_FAST = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic speedup,
  output logic tick
);
  localparam int MAXD = (TICK_NORM > TICK_FAST) ? TICK_NORM : TICK_FAST;
  localparam int PW   = $clog2(MAXD + 1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] last;

  assign last = speedup ? PW'(TICK_FAST - 1) : PW'(TICK_NORM - 1);
  assign tick = (cnt_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lia_beat_gen.sv
module lia_beat_gen #(
  parameter int TX_PERIOD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic tx_active,
  output logic pulse_req,
  output logic beat_due
);
  localparam int CW = $clog2(TX_PERIOD + 1);

  logic [CW-1:0] cnt_q;

  assign beat_due = tick && !tx_active && (cnt_q == CW'(TX_PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      pulse_req <= 1'b0;
    end else if (tx_active) begin
      cnt_q     <= '0;
      pulse_req <= 1'b0;
    end else if (beat_due) begin
      cnt_q     <= '0;
      pulse_req <= 1'b1;
    end else begin
      if (tick) cnt_q <= cnt_q + 1'b1;
      pulse_req <= 1'b0;
    end
  end
endmodule

// File: rtl/lia_link_mon.sv
module lia_link_mon
  import lia_pkg::*;
#(
  parameter int RX_MIN       = 4,
  parameter int RX_MAX       = 150,
  parameter int FAIL_TIMEOUT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx_pulse,
  input  logic rx_carrier,
  output logic link_fail,
  output logic spacing_ok,
  output logic timeout_hit
);
  localparam int GW = $clog2(RX_MAX + 2);
  localparam int TW = $clog2(FAIL_TIMEOUT + 1);
  localparam logic [GW-1:0] GAP_SAT = GW'(RX_MAX + 1);

  logic [GW-1:0] gap_q;
  logic [TW-1:0] to_q;
  logic          good_evt;

  assign spacing_ok  = gap_in_window(32'(gap_q), RX_MIN, RX_MAX);
  assign good_evt    = rx_carrier || (rx_pulse && spacing_ok);
  assign timeout_hit = tick && !link_fail && !good_evt && (to_q == TW'(FAIL_TIMEOUT - 1));

  // Ticks since the previous strobe, saturating just past the window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         gap_q <= GAP_SAT;
    else if (rx_pulse)                  gap_q <= '0;
    else if (tick && gap_q != GAP_SAT)  gap_q <= gap_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_fail <= 1'b1;
      to_q      <= '0;
    end else if (good_evt) begin
      link_fail <= 1'b0;
      to_q      <= '0;
    end else if (timeout_hit) begin
      link_fail <= 1'b1;
      to_q      <= '0;
    end else if (tick && !link_fail) begin
      to_q      <= to_q + 1'b1;
    end
  end
endmodule

// File: rtl/link_autoselect.sv
module link_autoselect
  import lia_pkg::*;
#(
  parameter int TICK_NORM    = 10000,
  parameter int TICK_FAST    = 4,
  parameter int TX_PERIOD    = 16,
  parameter int RX_MIN       = 4,
  parameter int RX_MAX       = 150,
  parameter int FAIL_TIMEOUT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic rx_pulse,
  input  logic rx_carrier,
  input  logic auto_sel,
  input  logic speedup,
  output logic link_pulse_req,
  output logic link_fail,
  output logic tp_tx_en,
  output logic tp_rx_en,
  output logic tp_lpbk_en,
  output logic aui_en
);
  logic tick;
  logic beat_due;
  logic spacing_ok;
  logic timeout_hit;
  logic tp_on;

  lia_tick_gen #(.TICK_NORM(TICK_NORM), .TICK_FAST(TICK_FAST)) u_tick (
    .clk(clk), .rst_n(rst_n), .speedup(speedup), .tick(tick)
  );

  lia_beat_gen #(.TX_PERIOD(TX_PERIOD)) u_beat (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_active(tx_active),
    .pulse_req(link_pulse_req), .beat_due(beat_due)
  );

  lia_link_mon #(.RX_MIN(RX_MIN), .RX_MAX(RX_MAX), .FAIL_TIMEOUT(FAIL_TIMEOUT)) u_mon (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_pulse(rx_pulse),
    .rx_carrier(rx_carrier), .link_fail(link_fail),
    .spacing_ok(spacing_ok), .timeout_hit(timeout_hit)
  );

  assign tp_on      = tp_selected(link_fail, auto_sel);
  assign tp_tx_en   = tp_on;
  assign tp_rx_en   = tp_on;
  assign tp_lpbk_en = tp_on;
  assign aui_en     = !tp_on;
endmodule

module lia_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_active,
  input logic rx_pulse,
  input logic rx_carrier,
  input logic auto_sel,
  input logic link_pulse_req,
  input logic link_fail,
  input logic tp_tx_en,
  input logic tp_rx_en,
  input logic tp_lpbk_en,
  input logic aui_en,
  input logic beat_due,
  input logic spacing_ok,
  input logic timeout_hit
);
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) link_pulse_req |=> !link_pulse_req); // R2
  AST_REQ_FROM_BEAT: assert property (@(posedge clk) disable iff (!rst_n) beat_due |=> link_pulse_req); // R2
  AST_NO_REQ_TX: assert property (@(posedge clk) disable iff (!rst_n) tx_active |=> !link_pulse_req); // R3
  AST_BAD_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (link_fail && rx_pulse && !spacing_ok && !rx_carrier) |=> link_fail); // R5
  AST_CARRIER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) rx_carrier |=> !link_fail); // R6
  AST_FAIL_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n) $rose(link_fail) |-> $past(timeout_hit)); // R7
  AST_MEDIA_EXCL: assert property (@(posedge clk) disable iff (!rst_n) (tp_tx_en != aui_en) && (tp_rx_en == tp_tx_en) && (tp_lpbk_en == tp_tx_en)); // R8
  AST_FORCE_TP: assert property (@(posedge clk) disable iff (!rst_n) !auto_sel |-> (tp_tx_en && tp_rx_en && tp_lpbk_en && !aui_en)); // R9
endmodule

bind link_autoselect lia_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .rx_pulse(rx_pulse),
  .rx_carrier(rx_carrier), .auto_sel(auto_sel), .link_pulse_req(link_pulse_req),
  .link_fail(link_fail), .tp_tx_en(tp_tx_en), .tp_rx_en(tp_rx_en),
  .tp_lpbk_en(tp_lpbk_en), .aui_en(aui_en), .beat_due(beat_due),
  .spacing_ok(spacing_ok), .timeout_hit(timeout_hit)
);

// File: tb/sim_link_autoselect.sv
`timescale 1ns/1ps
module sim_link_autoselect;
  localparam int TN = 24, TF = 3, TXP = 16, RMIN = 4, RMAX = 150, TO = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_active = 1'b0, rx_pulse = 1'b0, rx_carrier = 1'b0;
  logic auto_sel = 1'b1, speedup = 1'b1;
  logic link_pulse_req, link_fail, tp_tx_en, tp_rx_en, tp_lpbk_en, aui_en;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  link_autoselect #(.TICK_NORM(TN), .TICK_FAST(TF), .TX_PERIOD(TXP),
                    .RX_MIN(RMIN), .RX_MAX(RMAX), .FAIL_TIMEOUT(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .rx_pulse(rx_pulse),
    .rx_carrier(rx_carrier), .auto_sel(auto_sel), .speedup(speedup),
    .link_pulse_req(link_pulse_req), .link_fail(link_fail), .tp_tx_en(tp_tx_en),
    .tp_rx_en(tp_rx_en), .tp_lpbk_en(tp_lpbk_en), .aui_en(aui_en)
  );

  task automatic check(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: timers as plain integers, updated at each edge.
  int  m_presc, m_tx, m_gap, m_to;
  bit  m_fail, m_req;
  int  req_seen = 0;

  always @(posedge clk) begin
    int  lim;
    bit  tk, ok, tp;
    if (!rst_n) begin
      m_presc = 0; m_tx = 0; m_gap = RMAX + 1; m_to = 0; m_fail = 1; m_req = 0;
    end else begin
      lim = speedup ? TF - 1 : TN - 1;
      tk  = (m_presc >= lim);
      m_presc = tk ? 0 : m_presc + 1;
      ok  = rx_pulse && (m_gap >= RMIN) && (m_gap <= RMAX);
      if (tx_active) begin m_tx = 0; m_req = 0; end
      else if (tk && m_tx == TXP - 1) begin m_tx = 0; m_req = 1; end
      else begin if (tk) m_tx++; m_req = 0; end
      if (rx_pulse) m_gap = 0;
      else if (tk && m_gap < RMAX + 1) m_gap++;
      if (rx_carrier || ok) begin m_fail = 0; m_to = 0; end
      else if (tk && !m_fail) begin
        if (m_to == TO - 1) begin m_fail = 1; m_to = 0; end
        else m_to++;
      end
    end
    #1;
    if (rst_n) begin
      tp = !m_fail || !auto_sel;
      if (link_pulse_req) req_seen++;
      check("R2 link_pulse_req", link_pulse_req, m_req);
      check("R7 link_fail", link_fail, m_fail);
      check("R8 tp_tx_en", tp_tx_en, tp);
      check("R8 tp_rx_en", tp_rx_en, tp);
      check("R8 tp_lpbk_en", tp_lpbk_en, tp);
      check("R8 aui_en", aui_en, !tp);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe();
    rx_pulse = 1'b1; cyc(1); rx_pulse = 1'b0;
  endtask

  initial begin : watchdog
    #400000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int c0, gap_cycles;
    cyc(3);
    // R1: reset state
    check("R1 link_fail", link_fail, 1'b1);
    check("R1 aui_en", aui_en, 1'b1);
    check("R1 tp_tx_en", tp_tx_en, 1'b0);
    check("R1 link_pulse_req", link_pulse_req, 1'b0);
    rst_n = 1'b1;
    // R2: fast ticks, period 16*3 = 48 cycles
    cyc(200);
    check_int("R2 requests in 200 cycles", req_seen, 4);
    // R5: first strobe after reset is too late
    strobe(); cyc(1);
    check("R5 first strobe ignored", link_fail, 1'b1);
    // R4: strobe ~10 ticks later is valid
    cyc(29); strobe(); cyc(1);
    check("R4 valid spacing clears fail", link_fail, 1'b0);
    check("R8 tp on when good", tp_tx_en, 1'b1);
    check("R8 aui off when good", aui_en, 1'b0);
    // R7: timeout 100 ticks = 300 cycles
    cyc(285);
    check("R7 not yet failed", link_fail, 1'b0);
    cyc(20);
    check("R7 failed after timeout", link_fail, 1'b1);
    check("R8 aui on when failed", aui_en, 1'b1);
    // R5: too late (> 150 ticks since last strobe), then too early
    cyc(200); strobe(); cyc(1);
    check("R5 late strobe ignored", link_fail, 1'b1);
    cyc(5); strobe(); cyc(1);
    check("R5 early strobe ignored", link_fail, 1'b1);
    cyc(17); strobe(); cyc(1);
    check("R4 in-window strobe clears fail", link_fail, 1'b0);
    // R3: no requests while transmitting, period restarts after
    c0 = req_seen;
    tx_active = 1'b1; cyc(150);
    check_int("R3 no request while tx_active", req_seen - c0, 0);
    tx_active = 1'b0; cyc(44);
    check_int("R3 none before period after release", req_seen - c0, 0);
    cyc(8);
    check_int("R3 request one period after release", req_seen - c0, 1);
    // R6: carrier revives a failed link
    cyc(330);
    check("R7 failed again", link_fail, 1'b1);
    rx_carrier = 1'b1; cyc(1); rx_carrier = 1'b0; cyc(1);
    check("R6 carrier clears fail", link_fail, 1'b0);
    // R9: mode input low forces twisted pair on a failed link
    cyc(330);
    auto_sel = 1'b0; cyc(2);
    check("R9 link still failed", link_fail, 1'b1);
    check("R9 tp_tx_en forced", tp_tx_en, 1'b1);
    check("R9 tp_lpbk_en forced", tp_lpbk_en, 1'b1);
    check("R9 aui_en off", aui_en, 1'b0);
    auto_sel = 1'b1; cyc(2);
    check("R8 aui back on", aui_en, 1'b1);
    // R10: normal tick = 24 cycles, period 384 cycles
    speedup = 1'b0;
    while (!link_pulse_req) cyc(1);
    cyc(1);
    while (!link_pulse_req) cyc(1);
    gap_cycles = 0;
    cyc(1);
    while (!link_pulse_req) begin cyc(1); gap_cycles++; end
    check_int("R10 normal-tick request period", gap_cycles + 1, TXP * TN);
    cyc(4);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule